// File: doc/BRIEF.md
# Qualified Event Counter

This block is a single programmable performance-monitoring counter for a cache or uncore subsystem. Every clock cycle it looks at a set of event lanes, each carrying a small per-cycle count, a group of cache-lookup ports, and an occupancy level that gives the number of requests still outstanding. A control word chooses one event source by code. For lookups, a unit mask picks which line states count and, optionally, which request types. The counter then advances according to a threshold, an invert bit and an edge bit.

Software writes the control word and presets the 48-bit count through a small write port, and reads both back on plain output ports. All event inputs are sampled on every clock edge. They have no valid/ready handshake and cannot apply back-pressure, because a monitor must never stall the traffic it observes. A source that has nothing to report in a cycle drives a count of zero.

Control word layout: bits [7:0] event code, [15:8] unit mask, [23:16] threshold, bit 24 invert, bit 25 edge, bit 26 enable, bits [31:27] reserved (read as zero).

Top module: `qual_event_counter`

## Requirements
- R1: After reset the count output and the control readback are both zero.
- R2: An event code below NUM_LANES selects that lane. An event code of 0x21 selects the occupancy input and 0x20 selects the lookup ports. With threshold 0 and edge clear, each enabled cycle adds the full selected count. Any other code selects a count of zero.
- R3: With a non-zero threshold and invert clear, the count rises by exactly one in each enabled cycle whose selected count is greater than or equal to the threshold, and by zero otherwise.
- R4: With a non-zero threshold and invert set, the count rises by one in cycles whose selected count is strictly below the threshold. With threshold 0 the invert bit has no effect.
- R5: With edge set, the condition is the R3/R4 comparison, or "selected count non-zero" when the threshold is 0. The count rises by one only in a cycle where the condition is true and was false in the previous cycle. The previous-condition flag clears on reset and on every control-word write, and it is held false while the counter is disabled.
- R6: Lookup port state encoding is 0 = M, 1 = E, 2 = S, 3 = I. Unit mask bit n for n = 0..3 enables state n. A lookup counts when its port is valid, its state bit is set in the mask, and either mask bits [7:4] are all zero or a filter matches. Request-type bits per port are bit 0 read, bit 1 write and bit 2 external snoop. These are matched by mask bits 4, 5 and 6, and mask bit 7 matches any request. The lookup count is the number of matching ports in the cycle.
- R7: A lookup mask whose state bits [3:0] are all zero selects a count of zero, whatever filter bits it has.
- R8: The occupancy code (0x21) adds the occupancy level every enabled cycle, so the total is cycles weighted by outstanding requests.
- R9: A write with select 1 loads the count from the write data on the next edge. This takes priority over any increment in the same cycle, and it works whether or not the counter is enabled.
- R10: While the enable bit is clear and no count write occurs, the count holds its value.
- R11: The count wraps silently modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_cnt | input | NUM_LANES*EV_W | Per-cycle counts of the event lanes, lane 0 in the low bits |
| lk_valid | input | LK_PORTS | Lookup port active this cycle |
| lk_state | input | LK_PORTS*2 | Line state found by each lookup |
| lk_req | input | LK_PORTS*3 | Request-type bits of each lookup |
| occ_level | input | EV_W | Number of requests outstanding this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = count |
| wr_data | input | CNT_W | Write data; bits [31:0] for the control word |
| ctl_q | output | 32 | Control word readback |
| cnt_q | output | CNT_W | Current count |

## Verification
On every cycle, the assertions check the following: a count write wins over an increment, the count holds while disabled, and a threshold never yields more than one step per cycle. They also check that an edge step is never followed by another without a fresh false-to-true change, and that a mask without state bits selects nothing. Only the bench scenarios can show that the right amount is added. Those scenarios cover lane and occupancy selection, each mask and filter combination against a fixed lookup pattern, threshold boundaries with and without invert, the clearing of the edge history on a control rewrite, and the 48-bit wrap.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int CTL_W = 32;
  localparam logic [7:0] CODE_LOOKUP = 8'h20;
  localparam logic [7:0] CODE_OCC    = 8'h21;
  localparam int POS_INV  = 24;
  localparam int POS_EDGE = 25;
  localparam int POS_EN   = 26;

  typedef enum logic [1:0] {
    LS_MOD = 2'd0,
    LS_EXC = 2'd1,
    LS_SHR = 2'd2,
    LS_INV = 2'd3
  } line_state_e;

  typedef struct packed {
    logic [4:0] rsvd;
    logic       en;
    logic       edge_on;
    logic       inv;
    logic [7:0] thr;
    logic [7:0] umask;
    logic [7:0] code;
  } ctl_t;
endpackage

// File: rtl/qec_lookup_match.sv
module qec_lookup_match #(
  parameter int LK_PORTS = 4,
  parameter int CW = $clog2(LK_PORTS + 1)
) (
  input  logic [LK_PORTS-1:0]   valid,
  input  logic [LK_PORTS*2-1:0] state,
  input  logic [LK_PORTS*3-1:0] req,
  input  logic [7:0]            umask,
  output logic [CW-1:0]         match_cnt
);
  logic [LK_PORTS-1:0] hit;

  // one matcher per port: state bit AND (no filter OR any filter matches)
  for (genvar p = 0; p < LK_PORTS; p++) begin : g_port
    logic [1:0] st;
    logic [2:0] rq;
    logic       st_ok;
    logic       flt_ok;
    assign st     = state[p*2 +: 2];
    assign rq     = req[p*3 +: 3];
    assign st_ok  = umask[st];
    assign flt_ok = (umask[7:4] == 4'd0) || umask[7] || ((umask[6:4] & rq) != 3'd0);
    assign hit[p] = valid[p] && st_ok && flt_ok;
  end

  always_comb begin
    match_cnt = '0;
    for (int p = 0; p < LK_PORTS; p++) begin
      match_cnt = match_cnt + CW'(hit[p]);
    end
  end
endmodule

// File: rtl/qec_select.sv
module qec_select
  import qec_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int EV_W = 8,
  parameter int LK_PORTS = 4
) (
  input  logic [7:0]              code,
  input  logic [7:0]              umask,
  input  logic [NUM_LANES*EV_W-1:0] lane_cnt,
  input  logic [LK_PORTS-1:0]     lk_valid,
  input  logic [LK_PORTS*2-1:0]   lk_state,
  input  logic [LK_PORTS*3-1:0]   lk_req,
  input  logic [EV_W-1:0]         occ_level,
  output logic [EV_W-1:0]         sel_cnt
);
  localparam int LKC_W = $clog2(LK_PORTS + 1);

  logic [LKC_W-1:0] lk_cnt;

  qec_lookup_match #(.LK_PORTS(LK_PORTS), .CW(LKC_W)) u_match (
    .valid     (lk_valid),
    .state     (lk_state),
    .req       (lk_req),
    .umask     (umask),
    .match_cnt (lk_cnt)
  );

  always_comb begin
    sel_cnt = '0;
    if (code == CODE_LOOKUP) begin
      sel_cnt = EV_W'(lk_cnt);
    end else if (code == CODE_OCC) begin
      sel_cnt = occ_level;
    end else begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (code == 8'(l)) sel_cnt = lane_cnt[l*EV_W +: EV_W];
      end
    end
  end
endmodule

// File: rtl/qec_qualify.sv
module qec_qualify #(
  parameter int EV_W = 8,
  parameter int TH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] sel_cnt,
  input  logic [TH_W-1:0] thr,
  input  logic            inv,
  input  logic            edge_on,
  input  logic            en,
  input  logic            clr_prev,
  output logic [EV_W-1:0] inc
);
  localparam int CMP_W = (EV_W > TH_W) ? EV_W : TH_W;

  logic [CMP_W-1:0] c_ext;
  logic [CMP_W-1:0] t_ext;
  logic thr_zero;
  logic meets;
  logic cond;
  logic prev_q;
  logic edge_hit;

  assign c_ext    = CMP_W'(sel_cnt);
  assign t_ext    = CMP_W'(thr);
  assign thr_zero = (thr == '0);
  assign meets    = inv ? (c_ext < t_ext) : (c_ext >= t_ext);
  assign cond     = thr_zero ? (sel_cnt != '0) : meets;
  assign edge_hit = cond && !prev_q;

  always_comb begin
    if (edge_on)       inc = {{(EV_W-1){1'b0}}, edge_hit};
    else if (thr_zero) inc = sel_cnt;
    else               inc = {{(EV_W-1){1'b0}}, meets};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_prev) prev_q <= 1'b0;
    else                    prev_q <= cond && en;
  end
endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
  parameter int CNT_W = 48,
  parameter int EV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [EV_W-1:0]  inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (en)   cnt <= cnt + {{(CNT_W-EV_W){1'b0}}, inc};
  end
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int EV_W = 8,
  parameter int LK_PORTS = 4,
  parameter int CNT_W = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LANES*EV_W-1:0] lane_cnt,
  input  logic [LK_PORTS-1:0]       lk_valid,
  input  logic [LK_PORTS*2-1:0]     lk_state,
  input  logic [LK_PORTS*3-1:0]     lk_req,
  input  logic [EV_W-1:0]           occ_level,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [CNT_W-1:0]          wr_data,
  output logic [CTL_W-1:0]          ctl_q,
  output logic [CNT_W-1:0]          cnt_q
);
  ctl_t ctl_r;
  ctl_t ctl_nxt;
  logic ctl_wr;
  logic cnt_wr;
  logic [EV_W-1:0] sel_cnt;
  logic [EV_W-1:0] inc_amt;

  assign ctl_wr = wr_en && !wr_sel;
  assign cnt_wr = wr_en && wr_sel;

  always_comb begin
    ctl_nxt      = ctl_t'(wr_data[CTL_W-1:0]);
    ctl_nxt.rsvd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_r <= '0;
    else if (ctl_wr) ctl_r <= ctl_nxt;
  end

  assign ctl_q = ctl_r;

  qec_select #(.NUM_LANES(NUM_LANES), .EV_W(EV_W), .LK_PORTS(LK_PORTS)) u_sel (
    .code      (ctl_r.code),
    .umask     (ctl_r.umask),
    .lane_cnt  (lane_cnt),
    .lk_valid  (lk_valid),
    .lk_state  (lk_state),
    .lk_req    (lk_req),
    .occ_level (occ_level),
    .sel_cnt   (sel_cnt)
  );

  qec_qualify #(.EV_W(EV_W), .TH_W(8)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_cnt  (sel_cnt),
    .thr      (ctl_r.thr),
    .inv      (ctl_r.inv),
    .edge_on  (ctl_r.edge_on),
    .en       (ctl_r.en),
    .clr_prev (ctl_wr),
    .inc      (inc_amt)
  );

  qec_accum #(.CNT_W(CNT_W), .EV_W(EV_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_r.en),
    .load     (cnt_wr),
    .load_val (wr_data),
    .inc      (inc_amt),
    .cnt      (cnt_q)
  );
endmodule

// File: rtl/qec_checker.sv
module qec_checker
  import qec_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int EV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic [CTL_W-1:0] ctl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [EV_W-1:0]  sel_cnt,
  input logic [EV_W-1:0]  inc
);
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (cnt_q == $past(wr_data)));

  a_r10_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_sel) && !ctl_q[POS_EN]) |=> (cnt_q == $past(cnt_q)));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[23:16] != 8'd0 || ctl_q[POS_EDGE]) |-> (inc <= EV_W'(1)));

  a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[POS_EDGE] && ctl_q[POS_EN] && inc != '0 && !wr_en) |=> (inc == '0));

  a_r7_filter_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[7:0] == CODE_LOOKUP && ctl_q[11:8] == 4'd0) |-> (sel_cnt == '0));
endmodule

bind qual_event_counter qec_checker #(.CNT_W(CNT_W), .EV_W(EV_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .ctl_q   (ctl_q),
  .cnt_q   (cnt_q),
  .sel_cnt (sel_cnt),
  .inc     (inc_amt)
);

// File: tb/qual_event_counter_test.sv
module qual_event_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // shared stimulus: lanes 3..0 = 9,4,7,3; occupancy 11; four valid lookups
  // states M,E,S,I on ports 0..3; requests read, write, snoop, read
  localparam logic [63:0] ENV = {32'h09040703, 8'd11, 4'hF, 8'hE4, 12'h311};
  localparam logic [111:0] VEC [NV] = '{
    {32'h04000000, ENV, 16'd3},
    {32'h04000003, ENV, 16'd9},
    {32'h04000005, ENV, 16'd0},
    {32'h04050001, ENV, 16'd1},
    {32'h04070001, ENV, 16'd1},
    {32'h04080001, ENV, 16'd0},
    {32'h05080001, ENV, 16'd1},
    {32'h05070001, ENV, 16'd0},
    {32'h05000000, ENV, 16'd3},
    {32'h04000021, ENV, 16'd11},
    {32'h04000120, ENV, 16'd1},
    {32'h04000620, ENV, 16'd2},
    {32'h04000F20, ENV, 16'd4},
    {32'h04001F20, ENV, 16'd2},
    {32'h04002F20, ENV, 16'd1},
    {32'h04004E20, ENV, 16'd1},
    {32'h04008F20, ENV, 16'd4},
    {32'h0400F020, ENV, 16'd0},
    {32'h04030F20, ENV, 16'd1},
    {32'h00000003, ENV, 16'd0}
  };
  string tags [NV] = '{"R2", "R2", "R2", "R3", "R3", "R3", "R4", "R4", "R4", "R8",
                       "R6", "R6", "R6", "R6", "R6", "R6", "R6", "R7", "R3", "R10"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lane_cnt = '0;
  logic [3:0]  lk_valid = '0;
  logic [7:0]  lk_state = '0;
  logic [11:0] lk_req = '0;
  logic [7:0]  occ_level = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [47:0] wr_data = '0;
  logic [31:0] ctl_q;
  logic [47:0] cnt_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  qual_event_counter uut (
    .clk(clk), .rst_n(rst_n), .lane_cnt(lane_cnt), .lk_valid(lk_valid),
    .lk_state(lk_state), .lk_req(lk_req), .occ_level(occ_level),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctl_q(ctl_q), .cnt_q(cnt_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    lane_cnt = '0; lk_valid = '0; lk_state = '0; lk_req = '0; occ_level = '0;
  endtask

  task automatic wr(logic sel, logic [47:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1", cnt_q, 48'd0);
    chk("R1", {16'd0, ctl_q}, 48'd0);

    for (int i = 0; i < NV; i++) begin
      quiet();
      wr(1'b0, {16'd0, VEC[i][111:80]});
      wr(1'b1, 48'd0);
      lane_cnt  = VEC[i][79:48];
      occ_level = VEC[i][47:40];
      lk_valid  = VEC[i][39:36];
      lk_state  = VEC[i][35:28];
      lk_req    = VEC[i][27:16];
      cyc();
      chk(tags[i], cnt_q, {32'd0, VEC[i][15:0]});
    end

    // R9: load during active counting wins, then counting resumes
    quiet();
    wr(1'b0, 48'h04000000);
    lane_cnt = 32'd3;
    wr(1'b1, 48'd100);
    chk("R9", cnt_q, 48'd100);
    cyc();
    chk("R9", cnt_q, 48'd103);

    // R11: wrap at 2^48
    wr(1'b1, 48'hFFFF_FFFF_FFFE);
    cyc();
    chk("R11", cnt_q, 48'd1);

    // R5: edge on lane 0 with threshold 0
    quiet();
    wr(1'b0, 48'h06000000);
    wr(1'b1, 48'd0);
    lane_cnt = 32'd5;
    cyc(); cyc(); cyc();
    chk("R5", cnt_q, 48'd1);
    lane_cnt = 32'd0;
    cyc();
    lane_cnt = 32'd2;
    cyc();
    chk("R5", cnt_q, 48'd2);
    wr(1'b0, 48'h06000000);
    chk("R5", cnt_q, 48'd2);
    cyc();
    chk("R5", cnt_q, 48'd3);

    // R5: edge combined with threshold 4
    quiet();
    wr(1'b0, 48'h06040000);
    wr(1'b1, 48'd0);
    lane_cnt = 32'd3;
    cyc();
    chk("R5", cnt_q, 48'd0);
    lane_cnt = 32'd6;
    cyc();
    lane_cnt = 32'd9;
    cyc();
    chk("R5", cnt_q, 48'd1);

    // R10: disabled counter keeps a preset value while events arrive
    quiet();
    wr(1'b0, 48'h00000000);
    wr(1'b1, 48'd55);
    lane_cnt = 32'd7;
    cyc(); cyc();
    chk("R10", cnt_q, 48'd55);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule